// File: doc/BRIEF.md
# DMA Channel Control Register Slave

This block is the register front end for a group of DMA channels. The channel datapaths are not part of it. Software writes it through a simple word-addressed write port and reads it back through a combinational read port. A handful of shared control words hold the bus-burst enables, the per-channel clock gates, the per-channel interrupt enables, the completion status and the error status. Each shared word answers at four aliases. The base address writes the word outright. The second alias ORs the data in, the third clears the bits that are written as ones, and the fourth inverts them.

Above the shared words sits a per-channel window on a fixed stride. Each channel has a command-address register there, which loads the channel's first command pointer. It also has a semaphore port, which adds to the channel's pending-command count. Writes to these produce one-cycle strobes toward the addressed channel.

The channels report back through completion and error pulses, which latch into sticky status bits. The enabled completion bits combine into a single interrupt line. A build-time layout switch selects one of two variants. The variants differ in where the clock-gate and channel-reset fields sit and in where the per-channel window starts.

Top module: `dma_chan_regs`

## Requirements
- R1: Out of reset, every implemented clock-gate bit is 1, so every channel is stopped. Both burst enables are 0, the status and enable word is 0, the error word is 0, and `irq` is 0.
- R2: Each shared control word decodes at four aliases, selected by address bits [3:2]. Base +0x0 writes the word, +0x4 ORs in the data, +0x8 clears the bits written as one, and +0xC inverts them. A read at any alias returns the word.
- R3: Control word 0 sits at 0x000. Bit 29 drives `burst8En` and bit 28 drives `burstEn`. The clock gate for channel n is bit n in the newer layout and bit 8+n in the older one, and it drives `chanClkGate[n]`, where 1 stops the channel and 0 lets it run.
- R4: The word at 0x010 holds completion status for channel n in bit n and the interrupt enable for channel n in bit 16+n. A `chanDone[n]` pulse sets bit n at the clock edge where it is sampled, and it wins over a clear alias write to the same bit in the same cycle.
- R5: The word at 0x020 holds error status for channel n in bit n. A `chanErr[n]` pulse sets the bit, and it wins over a simultaneous clear.
- R6: `irq` is high exactly when some channel has both its completion bit and its enable bit set, and it follows the word with no further delay. Error bits do not affect it.
- R7: Channel reset bits self-clear. In the newer layout they are bit 16+n of the word at 0x030. In the older layout they are bit 16+n of control word 0. Writing 1 to one of them raises `chanRst[n]` for exactly the one cycle after the write, and afterwards the bit reads 0.
- R8: The command-address register of channel n is at CMD_BASE + n*0x70, where CMD_BASE is 0x110 (newer layout) or 0x050 (older layout). A write stores the value for readback and raises `cmdLoad[n]` for one cycle, with `cmdAddr` carrying the written value.
- R9: The semaphore port of channel n is at SEM_BASE + n*0x70, where SEM_BASE is 0x140 (newer layout) or 0x080 (older layout). A write raises `semaAdd[n]` for one cycle, with `semaIncr` equal to write data bits [7:0]. Reads of this port return 0.
- R10: Writes to unmapped or misaligned addresses, and to unimplemented bits, have no effect, and those bits and addresses read 0. In the older layout, 0x030 is unmapped.
- R11: The older layout supports at most 8 channels, because its clock-gate field (bits 8+n) would otherwise run into its reset field (bits 16+n). With 8 channels it behaves as R3, R7, R8 and R9 describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Write strobe for the register port |
| regAddr | input | 12 | Byte address for both reads and writes |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from `regAddr` |
| chanDone | input | NUM_CH | Per-channel command-complete pulses |
| chanErr | input | NUM_CH | Per-channel error pulses |
| chanClkGate | output | NUM_CH | Per-channel clock gate, where 1 stops the channel |
| chanRst | output | NUM_CH | One-cycle per-channel reset strobes |
| cmdLoad | output | NUM_CH | One-cycle command-address load strobes |
| cmdAddr | output | 32 | Command address that goes with `cmdLoad` |
| semaAdd | output | NUM_CH | One-cycle semaphore-add strobes |
| semaIncr | output | 8 | Increment that goes with `semaAdd` |
| burstEn | output | 1 | Bus burst enable |
| burst8En | output | 1 | Eight-beat burst enable |
| irq | output | 1 | Combined completion interrupt |

## Verification
Every register and every strobe changes at the first clock edge that samples a write or a channel pulse. The read data and `irq` are combinational from the registers. So the strobes and the new register contents are due one edge after the stimulus, and the strobes are gone again one edge later.

The bench drives each stimulus on a falling edge and lets one rising edge pass. It then inspects the strobes and reads the registers on the next falling edge, before the following rising edge can move anything. A further idle cycle confirms that the strobes have dropped. Randomized alias writes with colliding channel pulses are compared against a bench model of the three shared words.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 12;
  localparam int STRIDE     = 'h70;
  localparam int BURST8_BIT = 29;
  localparam int BURST_BIT  = 28;
  localparam int HI_POS     = 16;   // enables and reset bits start here

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_TOG = 2'd3
  } aliasOp_e;

  // Decoded access toward the datapath
  typedef struct packed {
    logic     wr;
    logic     selCtrl0;
    logic     selCtrl1;
    logic     selCtrl2;
    logic     selChCtrl;
    aliasOp_e op;
  } ctrlStrobe_t;

  function automatic logic [DATA_W-1:0] applyAlias(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] wd,
                                                   input aliasOp_e op);
    case (op)
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      OP_TOG:  return cur ^ wd;
      default: return wd;
    endcase
  endfunction
endpackage

// File: rtl/dmaRegCtrl.sv
module dmaRegCtrl
  import dmaRegPkg::*;
#(
  parameter int NUM_CH     = 13,
  parameter bit NEW_LAYOUT = 1'b1
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       stb,
  output logic [NUM_CH-1:0] cmdHit,
  output logic [NUM_CH-1:0] semHit
);
  localparam int CMD_BASE = NEW_LAYOUT ? 'h110 : 'h050;
  localparam int SEM_BASE = NEW_LAYOUT ? 'h140 : 'h080;

  logic              aligned;
  logic [ADDR_W-5:0] grp;

  assign aligned = (regAddr[1:0] == 2'b00);
  assign grp     = regAddr[ADDR_W-1:4];

  always_comb begin
    stb.wr        = regWe;
    stb.op        = aliasOp_e'(regAddr[3:2]);
    stb.selCtrl0  = aligned && (grp == (ADDR_W-4)'(0));
    stb.selCtrl1  = aligned && (grp == (ADDR_W-4)'(1));
    stb.selCtrl2  = aligned && (grp == (ADDR_W-4)'(2));
    stb.selChCtrl = NEW_LAYOUT && aligned && (grp == (ADDR_W-4)'(3));
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_win
    assign cmdHit[n] = (regAddr == ADDR_W'(CMD_BASE + n * STRIDE));
    assign semHit[n] = (regAddr == ADDR_W'(SEM_BASE + n * STRIDE));
  end
endmodule

// File: rtl/dmaRegDatapath.sv
module dmaRegDatapath
  import dmaRegPkg::*;
#(
  parameter int NUM_CH     = 13,
  parameter bit NEW_LAYOUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [NUM_CH-1:0] cmdHit,
  input  logic [NUM_CH-1:0] semHit,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [NUM_CH-1:0] chanDone,
  input  logic [NUM_CH-1:0] chanErr,
  output logic [DATA_W-1:0] regRdata,
  output logic [NUM_CH-1:0] chanClkGate,
  output logic [NUM_CH-1:0] chanRst,
  output logic [NUM_CH-1:0] cmdLoad,
  output logic [DATA_W-1:0] cmdAddr,
  output logic [NUM_CH-1:0] semaAdd,
  output logic [7:0]        semaIncr,
  output logic              burstEn,
  output logic              burst8En,
  output logic              irq,
  output logic [NUM_CH-1:0] doneStat,
  output logic [NUM_CH-1:0] errStat,
  output logic [NUM_CH-1:0] irqEn
);
  localparam int CG_POS = NEW_LAYOUT ? 0 : 8;
  localparam logic [DATA_W-1:0] CH_MASK  = DATA_W'((64'd1 << NUM_CH) - 64'd1);
  localparam logic [DATA_W-1:0] C0_MASK  = (DATA_W'(1) << BURST8_BIT) | (DATA_W'(1) << BURST_BIT)
                                         | (CH_MASK << CG_POS);
  localparam logic [DATA_W-1:0] C1_MASK  = CH_MASK | (CH_MASK << HI_POS);
  localparam logic [DATA_W-1:0] RST_MASK = CH_MASK << HI_POS;

  if (!NEW_LAYOUT && NUM_CH > 8) begin : g_bad
    $error("older layout holds at most 8 channels");
  end

  logic [DATA_W-1:0] ctrl0Q, ctrl1Q, ctrl2Q, rstQ;
  logic [DATA_W-1:0] ctrl0D, ctrl1D, ctrl2D, rstD;
  logic [DATA_W-1:0] cmdAddrQ [NUM_CH];
  logic [NUM_CH-1:0] cmdLoadQ, semaAddQ;
  logic [DATA_W-1:0] cmdAddrOutQ;
  logic [7:0]        semaIncrQ;
  logic              rstWr;

  assign rstWr = stb.wr && (NEW_LAYOUT ? stb.selChCtrl : stb.selCtrl0);

  always_comb begin
    ctrl0D = ctrl0Q;
    if (stb.wr && stb.selCtrl0) ctrl0D = applyAlias(ctrl0Q, regWdata, stb.op) & C0_MASK;

    rstD = '0;
    if (rstWr) rstD = applyAlias(rstQ, regWdata, stb.op) & RST_MASK;

    ctrl1D = ctrl1Q;
    if (stb.wr && stb.selCtrl1) ctrl1D = applyAlias(ctrl1Q, regWdata, stb.op) & C1_MASK;
    ctrl1D[NUM_CH-1:0] = ctrl1D[NUM_CH-1:0] | chanDone;   // pulse beats clear

    ctrl2D = ctrl2Q;
    if (stb.wr && stb.selCtrl2) ctrl2D = applyAlias(ctrl2Q, regWdata, stb.op) & CH_MASK;
    ctrl2D[NUM_CH-1:0] = ctrl2D[NUM_CH-1:0] | chanErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrl0Q      <= CH_MASK << CG_POS;   // all channels gated
      ctrl1Q      <= '0;
      ctrl2Q      <= '0;
      rstQ        <= '0;
      cmdLoadQ    <= '0;
      semaAddQ    <= '0;
      cmdAddrOutQ <= '0;
      semaIncrQ   <= '0;
    end else begin
      ctrl0Q   <= ctrl0D;
      ctrl1Q   <= ctrl1D;
      ctrl2Q   <= ctrl2D;
      rstQ     <= rstD;
      cmdLoadQ <= stb.wr ? cmdHit : '0;
      semaAddQ <= stb.wr ? semHit : '0;
      if (stb.wr && (cmdHit != '0)) cmdAddrOutQ <= regWdata;
      if (stb.wr && (semHit != '0)) semaIncrQ   <= regWdata[7:0];
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_cmd
    always_ff @(posedge clk) begin
      if (!rstN)                      cmdAddrQ[n] <= '0;
      else if (stb.wr && cmdHit[n])   cmdAddrQ[n] <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    if (stb.selCtrl0)  regRdata = ctrl0Q | (NEW_LAYOUT ? '0 : rstQ);
    if (stb.selCtrl1)  regRdata = ctrl1Q;
    if (stb.selCtrl2)  regRdata = ctrl2Q;
    if (stb.selChCtrl) regRdata = rstQ;
    for (int n = 0; n < NUM_CH; n++) begin
      if (cmdHit[n]) regRdata = cmdAddrQ[n];
    end
  end

  assign chanClkGate = ctrl0Q[CG_POS +: NUM_CH];
  assign chanRst     = rstQ[HI_POS +: NUM_CH];
  assign burst8En    = ctrl0Q[BURST8_BIT];
  assign burstEn     = ctrl0Q[BURST_BIT];
  assign doneStat    = ctrl1Q[NUM_CH-1:0];
  assign irqEn       = ctrl1Q[HI_POS +: NUM_CH];
  assign errStat     = ctrl2Q[NUM_CH-1:0];
  assign irq         = |(doneStat & irqEn);
  assign cmdLoad     = cmdLoadQ;
  assign cmdAddr     = cmdAddrOutQ;
  assign semaAdd     = semaAddQ;
  assign semaIncr    = semaIncrQ;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmaRegPkg::*;
#(
  parameter int NUM_CH     = 13,
  parameter bit NEW_LAYOUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [11:0]       regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [NUM_CH-1:0] chanDone,
  input  logic [NUM_CH-1:0] chanErr,
  output logic [NUM_CH-1:0] chanClkGate,
  output logic [NUM_CH-1:0] chanRst,
  output logic [NUM_CH-1:0] cmdLoad,
  output logic [31:0]       cmdAddr,
  output logic [NUM_CH-1:0] semaAdd,
  output logic [7:0]        semaIncr,
  output logic              burstEn,
  output logic              burst8En,
  output logic              irq
);
  ctrlStrobe_t       stb;
  logic [NUM_CH-1:0] cmdHit, semHit;
  logic [NUM_CH-1:0] doneStat, errStat, irqEn;

  dmaRegCtrl #(.NUM_CH(NUM_CH), .NEW_LAYOUT(NEW_LAYOUT)) ctrl_i (
    .regWe(regWe), .regAddr(regAddr), .stb(stb), .cmdHit(cmdHit), .semHit(semHit)
  );

  dmaRegDatapath #(.NUM_CH(NUM_CH), .NEW_LAYOUT(NEW_LAYOUT)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdHit(cmdHit), .semHit(semHit),
    .regWdata(regWdata), .chanDone(chanDone), .chanErr(chanErr),
    .regRdata(regRdata), .chanClkGate(chanClkGate), .chanRst(chanRst),
    .cmdLoad(cmdLoad), .cmdAddr(cmdAddr), .semaAdd(semaAdd), .semaIncr(semaIncr),
    .burstEn(burstEn), .burst8En(burst8En), .irq(irq),
    .doneStat(doneStat), .errStat(errStat), .irqEn(irqEn)
  );
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NUM_CH = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [NUM_CH-1:0] chanDone,
  input logic [NUM_CH-1:0] chanErr,
  input logic [NUM_CH-1:0] chanRst,
  input logic [NUM_CH-1:0] cmdLoad,
  input logic [NUM_CH-1:0] semaAdd,
  input logic              irq,
  input logic [NUM_CH-1:0] doneStat,
  input logic [NUM_CH-1:0] errStat,
  input logic [NUM_CH-1:0] irqEn
);
  AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (chanDone != '0) |=> ((doneStat & $past(chanDone)) == $past(chanDone))); // R4

  AST_ERR_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (chanErr != '0) |=> ((errStat & $past(chanErr)) == $past(chanErr))); // R5

  AST_IRQ_ON_ENABLED_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (((chanDone & irqEn) != '0) && !regWe) |=> irq); // R6

  AST_RST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ((chanRst != '0) && !regWe) |=> (chanRst == '0)); // R7

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdLoad)); // R8

  AST_LOAD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdLoad != '0) |-> $past(regWe)); // R8

  AST_SEMA_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(semaAdd)); // R9

  AST_SEMA_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (semaAdd != '0) |-> $past(regWe)); // R9
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rstN(rstN), .regWe(regWe), .chanDone(chanDone), .chanErr(chanErr),
  .chanRst(chanRst), .cmdLoad(cmdLoad), .semaAdd(semaAdd), .irq(irq),
  .doneStat(doneStat), .errStat(errStat), .irqEn(irqEn)
);

// File: tb/dma_chan_regs_tb_top.sv
`timescale 1ns/1ps
module dma_chan_regs_tb_top;
  localparam logic [31:0] M_C0 = 32'h3000_1FFF;
  localparam logic [31:0] M_C1 = 32'h1FFF_1FFF;
  localparam logic [31:0] M_C2 = 32'h0000_1FFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [12:0] chanDone = '0, chanErr = '0;

  logic [31:0] regRdata, cmdAddr;
  logic [12:0] chanClkGate, chanRst, cmdLoad, semaAdd;
  logic [7:0]  semaIncr;
  logic        burstEn, burst8En, irq;

  logic [31:0] oRdata, oCmdAddr;
  logic [7:0]  oClkGate, oRst, oCmdLoad, oSemaAdd, oSemaIncr;
  logic        oBurst, oBurst8, oIrq;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  dma_chan_regs #(.NUM_CH(13), .NEW_LAYOUT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .chanDone(chanDone), .chanErr(chanErr),
    .chanClkGate(chanClkGate), .chanRst(chanRst), .cmdLoad(cmdLoad), .cmdAddr(cmdAddr),
    .semaAdd(semaAdd), .semaIncr(semaIncr), .burstEn(burstEn), .burst8En(burst8En), .irq(irq)
  );

  dma_chan_regs #(.NUM_CH(8), .NEW_LAYOUT(1'b0)) dutOld_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(oRdata), .chanDone(chanDone[7:0]), .chanErr(chanErr[7:0]),
    .chanClkGate(oClkGate), .chanRst(oRst), .cmdLoad(oCmdLoad), .cmdAddr(oCmdAddr),
    .semaAdd(oSemaAdd), .semaIncr(oSemaIncr), .burstEn(oBurst), .burst8En(oBurst8), .irq(oIrq)
  );

  function automatic logic [31:0] modelOp(input logic [31:0] cur, input logic [31:0] wd,
                                          input int op);
    case (op)
      1:       return cur | wd;
      2:       return cur & ~wd;
      3:       return cur ^ wd;
      default: return wd;
    endcase
  endfunction

  function automatic logic modelIrq(input logic [31:0] c1);
    return |(c1[12:0] & c1[28:16]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive on a falling edge, let one rising edge pass, return on the next falling edge
  task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic [12:0] dn, input logic [12:0] er);
    regWe = we; regAddr = a; regWdata = d; chanDone = dn; chanErr = er;
    @(negedge clk);
    regWe = 1'b0; chanDone = '0; chanErr = '0;
  endtask

  task automatic readChk(input string req, input logic [11:0] a, input logic [31:0] exp);
    regAddr = a; #0.1;
    check(req, regRdata, exp);
  endtask

  task automatic readOld(input string req, input logic [11:0] a, input logic [31:0] exp);
    regAddr = a; #0.1;
    check(req, oRdata, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [31:0] mC0, mC1, mC2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readChk("R1 ctrl0", 12'h000, 32'h0000_1FFF);
    readChk("R1 status", 12'h010, 32'h0);
    readChk("R1 error", 12'h020, 32'h0);
    check("R1 irq", irq, 1'b0);
    check("R1 gates", chanClkGate, 13'h1FFF);
    check("R1 bursts", {burst8En, burstEn}, 2'b00);
    readOld("R11 R1 old ctrl0", 12'h000, 32'h0000_FF00);

    // R11 older layout
    step(1'b1, 12'h008, 32'h0000_0F00, '0, '0);
    check("R11 old gates", oClkGate, 8'hF0);
    readOld("R11 old ctrl0 clr", 12'h000, 32'h0000_F000);
    step(1'b1, 12'h004, 32'h0004_0000, '0, '0);
    check("R11 old reset strobe", oRst, 8'h04);
    check("R10 new ctrl0 ignores bit 18", chanRst, 13'h0);
    step(1'b0, 12'h000, 32'h0, '0, '0);
    check("R11 old reset drops", oRst, 8'h00);
    readOld("R11 old reset reads 0", 12'h000, 32'h0000_F000);
    step(1'b1, 12'h0C0, 32'hA5A5_0000, '0, '0);
    check("R11 old cmd load", oCmdLoad, 8'h02);
    check("R11 old cmd addr", oCmdAddr, 32'hA5A5_0000);
    check("R10 new unmapped 0x0C0", cmdLoad, 13'h0);
    step(1'b0, 12'h000, 32'h0, '0, '0);
    check("R11 old load drops", oCmdLoad, 8'h00);
    readOld("R11 old cmd readback", 12'h0C0, 32'hA5A5_0000);
    step(1'b1, 12'h080, 32'h0000_0155, '0, '0);
    check("R11 old sema add", oSemaAdd, 8'h01);
    check("R11 old sema incr", oSemaIncr, 8'h55);
    step(1'b1, 12'h030, 32'hFFFF_FFFF, '0, '0);
    check("R7 new reset all", chanRst, 13'h1FFF);
    check("R11 R10 old 0x030 unmapped", oRst, 8'h00);
    readOld("R11 R10 old 0x030 reads 0", 12'h030, 32'h0);
    step(1'b0, 12'h000, 32'h0, '0, '0);
    check("R7 new reset drops", chanRst, 13'h0);

    // Known state for the newer instance
    step(1'b1, 12'h000, 32'h0000_1FFF, '0, '0);
    step(1'b1, 12'h010, 32'h0, '0, '0);
    step(1'b1, 12'h020, 32'h0, '0, '0);

    // R3 control word 0 fields
    step(1'b1, 12'h000, 32'h3000_0005, '0, '0);
    check("R3 burst enables", {burst8En, burstEn}, 2'b11);
    check("R3 gates", chanClkGate, 13'h0005);
    step(1'b1, 12'h00C, 32'h1000_0003, '0, '0);
    check("R2 R3 toggle bursts", {burst8En, burstEn}, 2'b10);
    check("R2 R3 toggle gates", chanClkGate, 13'h0006);
    readChk("R2 alias read", 12'h008, 32'h2000_0006);

    // R7 channel reset strobe
    step(1'b1, 12'h034, 32'h0008_0000, '0, '0);
    check("R7 strobe ch3", chanRst, 13'h0008);
    step(1'b0, 12'h000, 32'h0, '0, '0);
    check("R7 strobe drops", chanRst, 13'h0);
    readChk("R7 self clear", 12'h030, 32'h0);

    // R8 command address, channel 5
    step(1'b1, 12'h340, 32'hDEAD_BEE0, '0, '0);
    check("R8 load ch5", cmdLoad, 13'h0020);
    check("R8 addr out", cmdAddr, 32'hDEAD_BEE0);
    step(1'b0, 12'h000, 32'h0, '0, '0);
    check("R8 load drops", cmdLoad, 13'h0);
    readChk("R8 readback", 12'h340, 32'hDEAD_BEE0);

    // R9 semaphore, channel 12
    step(1'b1, 12'h680, 32'h1234_5603, '0, '0);
    check("R9 add ch12", semaAdd, 13'h1000);
    check("R9 incr", semaIncr, 8'h03);
    readChk("R9 reads 0", 12'h680, 32'h0);
    step(1'b0, 12'h000, 32'h0, '0, '0);
    check("R9 add drops", semaAdd, 13'h0);

    // R10 unmapped, misaligned, unimplemented bits
    step(1'b1, 12'h040, 32'hFFFF_FFFF, '0, '0);
    readChk("R10 unmapped reads 0", 12'h040, 32'h0);
    readChk("R10 ctrl0 untouched", 12'h000, 32'h2000_0006);
    step(1'b1, 12'h001, 32'h0, '0, '0);
    readChk("R10 misaligned ignored", 12'h000, 32'h2000_0006);
    step(1'b1, 12'h020, 32'hFFFF_FFFF, '0, '0);
    readChk("R10 error word mask", 12'h020, 32'h0000_1FFF);
    step(1'b1, 12'h028, 32'h0000_1FFF, '0, '0);
    readChk("R2 clear alias", 12'h020, 32'h0);

    // R4 completion status and priority
    step(1'b0, 12'h000, 32'h0, 13'h0004, '0);
    readChk("R4 done sets", 12'h010, 32'h0000_0004);
    check("R6 no irq without enable", irq, 1'b0);
    step(1'b1, 12'h018, 32'h0000_0004, 13'h0004, '0);
    readChk("R4 done beats clear", 12'h010, 32'h0000_0004);
    step(1'b1, 12'h018, 32'h0000_0004, '0, '0);
    readChk("R4 clear works", 12'h010, 32'h0);

    // R6 interrupt
    step(1'b1, 12'h014, 32'h0004_0000, '0, '0);
    readChk("R4 enable bit", 12'h010, 32'h0004_0000);
    check("R6 enable alone", irq, 1'b0);
    step(1'b0, 12'h000, 32'h0, 13'h0002, '0);
    check("R6 other channel", irq, 1'b0);
    step(1'b0, 12'h000, 32'h0, 13'h0004, '0);
    check("R6 irq rises", irq, 1'b1);
    step(1'b1, 12'h018, 32'h0000_0006, '0, '0);
    check("R6 irq falls", irq, 1'b0);

    // R5 error status
    step(1'b0, 12'h000, 32'h0, '0, 13'h0010);
    readChk("R5 err sets", 12'h020, 32'h0000_0010);
    check("R6 err no irq", irq, 1'b0);
    step(1'b1, 12'h028, 32'h0000_0010, '0, 13'h0010);
    readChk("R5 err beats clear", 12'h020, 32'h0000_0010);
    step(1'b1, 12'h028, 32'h0000_0010, '0, '0);
    readChk("R5 err clear", 12'h020, 32'h0);

    // Random alias traffic against a bench model
    step(1'b1, 12'h000, 32'h0000_1FFF, '0, '0);
    step(1'b1, 12'h010, 32'h0, '0, '0);
    step(1'b1, 12'h020, 32'h0, '0, '0);
    mC0 = 32'h0000_1FFF; mC1 = '0; mC2 = '0;
    for (int i = 0; i < 400; i++) begin
      int          sel, op;
      logic [31:0] d;
      logic [12:0] dn, er;
      sel = int'($urandom % 3);
      op  = int'($urandom % 4);
      d   = $urandom;
      dn  = ($urandom % 4 == 0) ? 13'($urandom) : '0;
      er  = ($urandom % 4 == 0) ? 13'($urandom) : '0;
      case (sel)
        0:       mC0 = modelOp(mC0, d, op) & M_C0;
        1:       mC1 = modelOp(mC1, d, op) & M_C1;
        default: mC2 = modelOp(mC2, d, op) & M_C2;
      endcase
      mC1[12:0] = mC1[12:0] | dn;
      mC2[12:0] = mC2[12:0] | er;
      step(1'b1, 12'(sel * 16 + op * 4), d, dn, er);
      readChk("R2 R3 rand ctrl0", 12'(($urandom % 4) * 4), mC0);
      readChk("R2 R4 rand status", 12'(16 + ($urandom % 4) * 4), mC1);
      readChk("R2 R5 rand error", 12'(32 + ($urandom % 4) * 4), mC2);
      check("R6 rand irq", irq, modelIrq(mC1));
      check("R3 rand gates", {burst8En, burstEn, chanClkGate}, {mC0[29:28], mC0[12:0]});
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule